// File: doc/BRIEF.md
# Residue Channel Correlator

This block is one modulus slice of a residue-arithmetic signal processing datapath. It holds two rows of N residues each. The coefficient row is filled serially during a configuration phase and then held constant. The data row is a delay line that takes one new residue on every accepted input. Each of the N processing elements combines the coefficient and the data residue at its position, either by modular multiplication or by modular addition, as chosen by a per-position operation bit. A pipelined modular adder tree reduces the N results to a single residue.

The same array serves two configurations. In the FIR configuration, every position multiplies and the coefficient row holds the taps, so the output is the convolution of the taps with the stream, reduced modulo m. In the pattern search configuration, each position holds the additive inverse of the wanted symbol residue and adds. A don't-care position holds zero and multiplies. An output of zero then means the last N symbols match the pattern in this modulus. A channel enable freezes every register in the slice, so a modulus that is not needed for the chosen dynamic range causes no switching.

Top module: `rcc_channel`

## Requirements
- R1: After reset, dout and dout_valid are 0, all coefficients and data entries are 0, and every position is in add mode (operation bit 0).
- R2: On each rising edge with chan_en and cfg_load high, cfg_coef and cfg_mul enter position 0 and every older entry moves up one position. After N loads, the value loaded last sits at position 0 and the first one at position N-1. Operation bit 1 selects multiply and 0 selects add.
- R3: On each rising edge with chan_en and din_valid high, din enters data position 0 and data position k takes the old position k-1. Without din_valid, the data row holds.
- R4: Position k yields (A[k]*B[k]) mod m in multiply mode and (A[k]+B[k]) mod m in add mode. Input residues are assumed to be below m.
- R5: dout is the sum of all N position results modulo m, and always lies in 0..m-1, including when every operand is m-1.
- R6: dout_valid is high after the (clog2(N)+1)-th enabled rising edge that follows the edge that accepted din_valid. At that time, dout is the sum for the coefficient and data rows as they stood right after that accepting edge.
- R7: With all positions in multiply mode, dout is the sum over k of A[k]*x(n-k) mod m. An impulse therefore reads the coefficients out in position order, 0 first.
- R8: With inverse residues in the non-wildcard positions (add mode) and zero in the wildcard positions (multiply mode), dout is 0 when the last N symbols match the pattern, and not 0 when exactly one non-wildcard symbol differs.
- R9: While chan_en is low, no register changes: dout and dout_valid hold, and cfg_load and din_valid have no effect on later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low freezes every register |
| cfg_load | input | 1 | Shift one coefficient and operation bit into the coefficient row |
| cfg_coef | input | W | Coefficient residue to load |
| cfg_mul | input | 1 | Operation bit to load: 1 multiply, 0 add |
| din_valid | input | 1 | Accept din into the data row |
| din | input | W | Data residue |
| dout_valid | output | 1 | dout carries the sum for an accepted input |
| dout | output | W | Residue sum modulo m |

## Verification
The bench builds the channel with modulus 13 and 6 positions. The position count is not a power of two, so two leaves of the eight-leaf tree are padded with zeros, and the latency is four cycles. The 4-bit residue leaves the codes 13 to 15 unused, so any escape of an unreduced sum would show. The largest product, 144, needs a real reduction step rather than a single subtraction. Random configurations, random gaps in the stream, and random enable drops are mixed with a reversed-order impulse readout, a wildcard match and mismatch, and all-operand-maximum sums.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic {PE_ADD = 1'b0, PE_MUL = 1'b1} pe_op_e;

  // operands are assumed reduced (< m)
  function automatic int unsigned mod_add(int unsigned a, int unsigned b, int unsigned m);
    int unsigned s;
    s = a + b;
    if (s >= m) s = s - m;
    return s;
  endfunction

  function automatic int unsigned mod_mul(int unsigned a, int unsigned b, int unsigned m);
    return (a * b) % m;
  endfunction

endpackage

// File: rtl/rcc_cfg_store.sv
module rcc_cfg_store #(
  parameter int N = 8,
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] coef_i,
  input  logic         mul_i,
  output logic [W-1:0] coef_o [N],
  output logic [N-1:0] mul_o
);

  logic [W-1:0] a_q [N];
  logic [W-1:0] a_d [N];
  logic [N-1:0] m_q, m_d;

  // next state: shift toward higher positions, new entry at 0
  always_comb begin
    a_d[0] = coef_i;
    for (int k = 1; k < N; k++) a_d[k] = a_q[k-1];
    m_d = {m_q[N-2:0], mul_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) a_q[k] <= '0;
      m_q <= '0;
    end else if (en && load) begin
      a_q <= a_d;
      m_q <= m_d;
    end
  end

  assign coef_o = a_q;
  assign mul_o  = m_q;

  // R2: loads shift the row by one position
  p_cfg_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> (a_q[N-1] == $past(a_q[N-2])) && (a_q[0] == $past(coef_i)));

  // R2, R9: without an enabled load the row holds
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && load) |=> $stable(m_q) && (a_q[N-1] == $past(a_q[N-1])) && (a_q[0] == $past(a_q[0])));

endmodule

// File: rtl/rcc_data_line.sv
module rcc_data_line #(
  parameter int N = 8,
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         valid,
  input  logic [W-1:0] din,
  output logic [W-1:0] b_o [N]
);

  logic [W-1:0] b_q [N];
  logic [W-1:0] b_d [N];

  always_comb begin
    b_d[0] = din;
    for (int k = 1; k < N; k++) b_d[k] = b_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) b_q[k] <= '0;
    end else if (en && valid) begin
      b_q <= b_d;
    end
  end

  assign b_o = b_q;

  // R3: accepted residue enters position 0, oldest moves on
  p_line_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && valid) |=> (b_q[0] == $past(din)) && (b_q[N-1] == $past(b_q[N-2])));

  // R3, R9: no acceptance, no movement
  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && valid) |=> (b_q[0] == $past(b_q[0])) && (b_q[N-1] == $past(b_q[N-1])));

endmodule

// File: rtl/rcc_pe.sv
module rcc_pe import rcc_pkg::*; #(
  parameter int unsigned MOD = 17,
  parameter int          W   = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         mul_i,
  output logic [W-1:0] r_o
);

  pe_op_e       op;
  logic [W-1:0] r_d, r_q;

  always_comb begin
    op = mul_i ? PE_MUL : PE_ADD;
    case (op)
      PE_MUL:  r_d = W'(mod_mul(32'(a_i), 32'(b_i), MOD));
      default: r_d = W'(mod_add(32'(a_i), 32'(b_i), MOD));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  r_q <= '0;
    else if (en) r_q <= r_d;
  end

  assign r_o = r_q;

  // R4: a position result is always a reduced residue
  p_pe_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(r_q) < MOD);

endmodule

// File: rtl/rcc_sum_tree.sv
module rcc_sum_tree import rcc_pkg::*; #(
  parameter int unsigned MOD = 17,
  parameter int          N   = 8,
  parameter int          W   = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] leaf_i [N],
  output logic [W-1:0] sum_o
);

  localparam int L     = $clog2(N);
  localparam int P     = 1 << L;
  localparam int NODES = P - 1;

  // heap layout: 0 is the root, children of i are 2i+1 and 2i+2
  logic [W-1:0] val    [2*P-1];
  logic [W-1:0] node_q [NODES];
  logic [W-1:0] node_d [NODES];

  for (genvar i = 0; i < NODES; i++) begin : g_inner
    assign val[i] = node_q[i];
  end

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j < N) begin : g_used
      assign val[NODES+j] = leaf_i[j];
    end else begin : g_pad
      assign val[NODES+j] = '0;
    end
  end

  always_comb begin
    for (int i = 0; i < NODES; i++)
      node_d[i] = W'(mod_add(32'(val[2*i+1]), 32'(val[2*i+2]), MOD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) node_q[i] <= '0;
    end else if (en) begin
      node_q <= node_d;
    end
  end

  assign sum_o = node_q[0];

  // R5: the root never leaves the residue range
  p_sum_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(node_q[0]) < MOD);

endmodule

// File: rtl/rcc_channel.sv
module rcc_channel import rcc_pkg::*; #(
  parameter int unsigned MOD = 17,
  parameter int          N   = 8,
  parameter int          W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chan_en,
  input  logic         cfg_load,
  input  logic [W-1:0] cfg_coef,
  input  logic         cfg_mul,
  input  logic         din_valid,
  input  logic [W-1:0] din,
  output logic         dout_valid,
  output logic [W-1:0] dout
);

  localparam int L   = $clog2(N);
  localparam int LAT = L + 1;

  logic [W-1:0] coef  [N];
  logic [N-1:0] mul;
  logic [W-1:0] bval  [N];
  logic [W-1:0] pe_r  [N];
  logic [LAT:0] v_q, v_d;

  rcc_cfg_store #(.N(N), .W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en(chan_en), .load(cfg_load),
    .coef_i(cfg_coef), .mul_i(cfg_mul), .coef_o(coef), .mul_o(mul)
  );

  rcc_data_line #(.N(N), .W(W)) u_line (
    .clk(clk), .rst_n(rst_n), .en(chan_en), .valid(din_valid),
    .din(din), .b_o(bval)
  );

  for (genvar k = 0; k < N; k++) begin : g_pe
    rcc_pe #(.MOD(MOD), .W(W)) u_pe (
      .clk(clk), .rst_n(rst_n), .en(chan_en),
      .a_i(coef[k]), .b_i(bval[k]), .mul_i(mul[k]), .r_o(pe_r[k])
    );
  end

  rcc_sum_tree #(.MOD(MOD), .N(N), .W(W)) u_tree (
    .clk(clk), .rst_n(rst_n), .en(chan_en), .leaf_i(pe_r), .sum_o(dout)
  );

  // valid flag: stage 0 marks the accepting edge, stage LAT the root
  assign v_d = {v_q[LAT-1:0], din_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       v_q <= '0;
    else if (chan_en) v_q <= v_d;
  end

  assign dout_valid = v_q[LAT];

  // R9: a frozen channel keeps its outputs
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> $stable(dout) && $stable(dout_valid));

endmodule

// File: tb/sim_rcc_channel.sv
`timescale 1ns/1ps
module sim_rcc_channel;

  localparam int MOD = 13;
  localparam int N   = 6;
  localparam int W   = $clog2(MOD);
  localparam int LAT = $clog2(N) + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chan_en = 1'b0;
  logic         cfg_load = 1'b0;
  logic [W-1:0] cfg_coef = '0;
  logic         cfg_mul = 1'b0;
  logic         din_valid = 1'b0;
  logic [W-1:0] din = '0;
  logic         dout_valid;
  logic [W-1:0] dout;

  always #2.5 clk = ~clk;

  rcc_channel #(.MOD(MOD), .N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_load(cfg_load),
    .cfg_coef(cfg_coef), .cfg_mul(cfg_mul), .din_valid(din_valid), .din(din),
    .dout_valid(dout_valid), .dout(dout)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench reference state
  int ma [N];
  int mm [N];
  int mb [N];
  int pv [LAT+1];
  int pd [LAT+1];

  function automatic int ref_sum();
    int s = 0;
    for (int k = 0; k < N; k++) begin
      int t = (mm[k] != 0) ? (ma[k] * mb[k]) % MOD : (ma[k] + mb[k]) % MOD;
      s = (s + t) % MOD;
    end
    return s;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive after negedge, update reference at posedge, compare at negedge
  task automatic cyc(bit en, bit ld, int c, bit m, bit v, int d);
    chan_en = en; cfg_load = ld; cfg_coef = W'(c); cfg_mul = m;
    din_valid = v; din = W'(d);
    @(posedge clk);
    if (en) begin
      if (ld) begin
        for (int k = N-1; k > 0; k--) begin ma[k] = ma[k-1]; mm[k] = mm[k-1]; end
        ma[0] = c; mm[0] = m;
      end
      if (v) begin
        for (int k = N-1; k > 0; k--) mb[k] = mb[k-1];
        mb[0] = d;
      end
      for (int i = LAT; i > 0; i--) begin pv[i] = pv[i-1]; pd[i] = pd[i-1]; end
      pv[0] = v; pd[0] = ref_sum();
    end
    @(negedge clk);
    chk(int'(dout_valid) == pv[LAT], "R6 valid latency", int'(dout_valid), pv[LAT]);
    if (pv[LAT] != 0) chk(int'(dout) == pd[LAT], "R5 R4 modular sum", int'(dout), pd[LAT]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int taps [N];
    int pat  [N];
    bit wild [N];
    int hold_v;
    void'($urandom(32'd20021));
    for (int k = 0; k < N; k++) begin ma[k] = 0; mm[k] = 0; mb[k] = 0; end
    for (int i = 0; i <= LAT; i++) begin pv[i] = 0; pd[i] = 0; end

    repeat (3) @(negedge clk);
    chk(dout == '0, "R1 reset dout", int'(dout), 0);
    chk(dout_valid == 1'b0, "R1 reset valid", int'(dout_valid), 0);
    rst_n = 1'b1;

    // R1: zero coefficients in add mode pass the data sum through
    cyc(1, 0, 0, 0, 1, 7);
    idle(LAT);
    chk(int'(dout) == 7, "R1 reset add mode zero coef", int'(dout), 7);

    // R2 R7: impulse reads taps back in reverse load order
    for (int i = 0; i < N; i++) begin
      taps[i] = $urandom_range(MOD-1);
      cyc(1, 1, taps[i], 1, 0, 0);
    end
    for (int i = 0; i < N; i++) cyc(1, 0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 1, 1);
    for (int j = 1; j < LAT + N; j++) begin
      cyc(1, 0, 0, 0, 1, 0);
      if (j >= LAT)
        chk(int'(dout) == taps[N-1-(j-LAT)], "R2 R7 impulse tap order",
            int'(dout), taps[N-1-(j-LAT)]);
    end

    // R5: every operand at m-1, multiply then add
    for (int i = 0; i < N; i++) cyc(1, 1, MOD-1, 1, 0, 0);
    for (int i = 0; i < N; i++) cyc(1, 0, 0, 0, 1, MOD-1);
    idle(LAT);
    chk(int'(dout) == (N * (MOD-1) * (MOD-1)) % MOD, "R5 max product sum",
        int'(dout), (N * (MOD-1) * (MOD-1)) % MOD);
    for (int i = 0; i < N; i++) cyc(1, 1, MOD-1, 0, 0, 0);
    idle(LAT);
    chk(int'(dout) == (N * 2 * (MOD-1)) % MOD, "R5 max add sum",
        int'(dout), (N * 2 * (MOD-1)) % MOD);

    // R8: pattern with wildcards at positions 1 and 4
    for (int k = 0; k < N; k++) begin
      pat[k]  = $urandom_range(MOD-1);
      wild[k] = (k == 1) || (k == 4);
    end
    for (int k = N-1; k >= 0; k--)
      cyc(1, 1, wild[k] ? 0 : (MOD - pat[k]) % MOD, wild[k], 0, 0);
    for (int k = N-1; k >= 0; k--)
      cyc(1, 0, 0, 0, 1, wild[k] ? $urandom_range(MOD-1) : pat[k]);
    idle(LAT);
    chk(int'(dout) == 0, "R8 pattern match", int'(dout), 0);
    for (int k = N-1; k >= 0; k--)
      cyc(1, 0, 0, 0, 1, wild[k] ? $urandom_range(MOD-1) :
                         (k == 2 ? (pat[k] + 1) % MOD : pat[k]));
    idle(LAT);
    chk(int'(dout) != 0, "R8 one symbol differs", int'(dout), 1);

    // R9: frozen channel ignores loads and data, outputs hold
    hold_v = int'(dout);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 1, 3, 1, 1, 5);
      chk(int'(dout) == hold_v, "R9 frozen output holds", int'(dout), hold_v);
    end
    idle(LAT);
    chk(int'(dout) == ref_sum(), "R9 state untouched after freeze", int'(dout), ref_sum());

    // R3 R4 R6 R9: random configurations, gaps and enable drops
    for (int i = 0; i < 600; i++) begin
      cyc($urandom_range(9) != 0, $urandom_range(11) == 0, $urandom_range(MOD-1),
          $urandom_range(1) == 1, $urandom_range(9) < 7, $urandom_range(MOD-1));
    end
    idle(LAT);
    chk(int'(dout) == ref_sum(), "R3 final state sum", int'(dout), ref_sum());

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule